// File: doc/BRIEF.md
# Strobe-Read Async Character Retimer

This block sits behind a demodulator that produces a 1200 baud asynchronous bit stream and lets a host without a UART collect each character one bit at a time. It waits for a high-to-low edge on the data line, which is the start of a start bit. It confirms the start bit at its centre, then samples the eight data bits at their centres using a 16x oversampling tick. The eight bits are collected into a shift register, least significant (first received) bit first.

When a character is complete and the host strobe is low, the block pulls its active-low interrupt low and presents the first stored bit on the data output. The host then pulses the strobe eight times. The first rising edge clears the interrupt. Each of the first seven falling edges steps to the next stored bit. The eighth falling edge returns the data output to live pass-through. A host that keeps the strobe high never sees an interrupt, and the output simply follows the line.

The data line and the strobe are each synchronised with two flops. The oversampling tick comes from a system-clock divider with a parameterised ratio. While a stored character is being read out, no new start edge is accepted.

Top module: `strobe_retimer`

## Requirements
- R1: With no stored character being presented, rxd_o equals the synchronised data input (two clock cycles of latency).
- R2: A high-to-low edge on rx_data_i starts a character. With one oversampling tick every CLK_DIV clocks and OVS ticks per bit, each of the 8 following data bits is sampled at its centre and stored, first received bit as bit 0.
- R3: If the line is high again at the centre of the start bit, the capture is abandoned and no interrupt is raised. The block then resumes hunting for a start edge.
- R4: If strobe_i is low when the eighth data bit is stored, irq_no goes low and rxd_o shows stored bit 0.
- R5: irq_no returns high on the first rising edge of strobe_i after it went low.
- R6: Each of the first seven falling edges of strobe_i during readout advances rxd_o to the next stored bit, bit 1 through bit 7 in order.
- R7: The eighth falling edge of strobe_i ends the readout, and rxd_o returns to pass-through.
- R8: If strobe_i is high when a character completes, that character is dropped. irq_no stays high and rxd_o stays in pass-through, even after strobe_i later goes low.
- R9: While a stored character is being presented, start edges are ignored. A character that arrives then is neither captured nor reported, and the stored character is read out intact.
- R10: Out of reset, irq_no is high and rxd_o is in pass-through with the idle (high) line value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 1 | Demodulated serial data, idle high |
| strobe_i | input | 1 | Host read strobe |
| rxd_o | output | 1 | Stored bit during readout, otherwise live data |
| irq_no | output | 1 | Character-ready interrupt, active low |

## Verification
The assertions take for granted that rx_data_i and strobe_i change slowly compared with the clock. They assume each level lasts longer than the two synchroniser stages plus one edge-detect register, and that the host completes a readout before it expects the next character to be reported. The stimulus holds every serial bit for a full OVS*CLK_DIV clocks and every strobe level for ten clocks. It starts a new frame only after a readout has finished, except in the test that deliberately sends a frame during readout to exercise R9. Outputs are sampled at bit centres or six clocks after a strobe edge, well past the synchroniser and register latency.

// File: rtl/retime_pkg.sv
package retime_pkg;
  typedef enum logic [1:0] {
    CAP_HUNT  = 2'd0,
    CAP_START = 2'd1,
    CAP_DATA  = 2'd2
  } cap_state_t;
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int          WIDTH     = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int DIV = 2604
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= '0;
      end
    end else begin : g_div
      assign tick_o = (cnt_q == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/char_capture.sv
module char_capture
  import retime_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 line_i,
  input  logic                 busy_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] byte_o
);
  localparam int CW = $clog2(OVS);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] MID   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL  = CW'(OVS - 1);
  localparam logic [IW-1:0] LASTB = IW'(DATA_BITS - 1);

  cap_state_t           st_q;
  logic [CW-1:0]        cnt_q;
  logic [IW-1:0]        idx_q;
  logic                 prev_q;
  logic [DATA_BITS-1:0] sh_q;

  wire start_edge = prev_q & ~line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CAP_HUNT;
      cnt_q  <= '0;
      idx_q  <= '0;
      prev_q <= 1'b1;
      sh_q   <= '0;
      done_o <= 1'b0;
    end else begin
      prev_q <= line_i;
      done_o <= 1'b0;
      unique case (st_q)
        CAP_HUNT: if (start_edge && !busy_i) begin
          st_q  <= CAP_START;
          cnt_q <= '0;
        end
        CAP_START: if (tick_i) begin
          if (cnt_q == MID) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= line_i ? CAP_HUNT : CAP_DATA;  // false start aborts
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        CAP_DATA: if (tick_i) begin
          if (cnt_q == FULL) begin
            cnt_q <= '0;
            sh_q  <= {line_i, sh_q[DATA_BITS-1:1]};
            if (idx_q == LASTB) begin
              st_q   <= CAP_HUNT;
              done_o <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= CAP_HUNT;
      endcase
    end
  end

  assign byte_o = sh_q;

  assert_suspend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && st_q == CAP_HUNT) |=> st_q == CAP_HUNT);
  assert_false_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CAP_START && tick_i && cnt_q == MID && line_i) |=> (st_q == CAP_HUNT && !done_o));
  assert_done_from_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(st_q == CAP_DATA && tick_i));
endmodule

// File: rtl/bit_readout.sv
module bit_readout #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic                 line_i,
  input  logic                 done_i,
  input  logic [DATA_BITS-1:0] byte_i,
  output logic                 rxd_o,
  output logic                 irq_no,
  output logic                 busy_o
);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [IW-1:0] LASTF = IW'(DATA_BITS - 1);

  logic                 strobe_q, active_q, irq_q;
  logic [IW-1:0]        fall_q;
  logic [DATA_BITS-1:0] sh_q;

  wire rise = strobe_i & ~strobe_q;
  wire fall = ~strobe_i & strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b1;
      active_q <= 1'b0;
      irq_q    <= 1'b0;
      fall_q   <= '0;
      sh_q     <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (!active_q) begin
        if (done_i && !strobe_i) begin  // strobe held high drops the byte
          active_q <= 1'b1;
          irq_q    <= 1'b1;
          fall_q   <= '0;
          sh_q     <= byte_i;
        end
      end else begin
        if (rise) irq_q <= 1'b0;
        if (fall) begin
          if (fall_q == LASTF) begin
            active_q <= 1'b0;
          end else begin
            fall_q <= fall_q + 1'b1;
            sh_q   <= sh_q >> 1;
          end
        end
      end
    end
  end

  assign rxd_o  = active_q ? sh_q[0] : line_i;
  assign irq_no = ~irq_q;
  assign busy_o = active_q;

  assert_irq_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && rise) |=> irq_no);
  assert_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && fall && fall_q != LASTF) |=> (active_q && rxd_o == $past(sh_q[1])));
  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && fall && fall_q == LASTF) |=> !busy_o);
  assert_irq_needs_active_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> busy_o);
endmodule

// File: rtl/strobe_retimer.sv
module strobe_retimer #(
  parameter int CLK_DIV   = 2604,
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_data_i,
  input  logic strobe_i,
  output logic rxd_o,
  output logic irq_no
);
  logic [1:0]           sync_s;
  logic                 line_s, strobe_s, tick, done, busy;
  logic [DATA_BITS-1:0] cap_byte;

  sync_2ff #(.WIDTH(2), .RESET_VAL(2'b11)) u_sync (
    .clk_i, .rst_ni, .d_i({strobe_i, rx_data_i}), .q_o(sync_s));
  assign line_s   = sync_s[0];
  assign strobe_s = sync_s[1];

  tick_gen #(.DIV(CLK_DIV)) u_tick (.clk_i, .rst_ni, .tick_o(tick));

  char_capture #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_cap (
    .clk_i, .rst_ni, .tick_i(tick), .line_i(line_s), .busy_i(busy),
    .done_o(done), .byte_o(cap_byte));

  bit_readout #(.DATA_BITS(DATA_BITS)) u_rd (
    .clk_i, .rst_ni, .strobe_i(strobe_s), .line_i(line_s), .done_i(done),
    .byte_i(cap_byte), .rxd_o, .irq_no, .busy_o(busy));

  assert_drop_on_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && strobe_s && !busy) |=> (!busy && irq_no));
  assert_passthru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no && !busy |-> rxd_o == line_s);
endmodule

// File: tb/strobe_retimer_test.sv
module strobe_retimer_test;
  localparam int DIV = 4;
  localparam int OVS = 16;
  localparam int BIT_T = DIV * OVS;
  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{8'h35, 8'h6A, 8'h01, 8'h7E, 8'h00, 8'hFF};

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, stb = 1'b0;
  logic rxd, irq_n;
  int checks = 0, fails = 0;
  bit irq_seen = 1'b0;

  strobe_retimer #(.CLK_DIV(DIV), .OVS(OVS), .DATA_BITS(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx), .strobe_i(stb),
    .rxd_o(rxd), .irq_no(irq_n));

  always #4 clk = ~clk;
  always @(negedge clk) if (rst_n && !irq_n) irq_seen = 1'b1;

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic send_frame(logic [7:0] b, bit check_pt);
    rx = 1'b0;
    wclk(BIT_T);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      wclk(BIT_T / 2);
      if (check_pt) chk("R1 pass-through mid-bit", rxd, b[i]);
      wclk(BIT_T / 2);
    end
    rx = 1'b1;
    wclk(BIT_T);
  endtask

  task automatic read_byte(logic [7:0] exp);
    chk("R4 irq low on ready", irq_n, 1'b0);
    chk("R4 first bit (LSB)", rxd, exp[0]);
    for (int i = 0; i < 8; i++) begin
      stb = 1'b1;
      wclk(6);
      if (i == 0) chk("R5 irq cleared by first strobe", irq_n, 1'b1);
      wclk(4);
      stb = 1'b0;
      wclk(6);
      if (i < 7) chk("R6 next bit on falling edge", rxd, exp[i+1]);
      else       chk("R7 back to pass-through", rxd, rx);
      wclk(4);
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wclk(5);
    chk("R10 reset irq high", irq_n, 1'b1);
    chk("R10 reset rxd idle", rxd, 1'b1);
    rst_n = 1'b1;
    wclk(20);

    // table: R2 capture / R4..R7 readout
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v], 1'b0);
      read_byte(VEC[v]);
      wclk(BIT_T);
    end

    // R8: strobe high at completion drops the byte
    stb = 1'b1;
    wclk(10);
    irq_seen = 1'b0;
    send_frame(8'h3C, 1'b1);
    stb = 1'b0;
    wclk(BIT_T);
    chk("R8 no irq with strobe high", irq_seen, 1'b0);
    chk("R8 rxd still pass-through", rxd, 1'b1);

    // R3: short glitch is a false start
    irq_seen = 1'b0;
    rx = 1'b0;
    wclk(16);
    rx = 1'b1;
    wclk(12 * BIT_T);
    chk("R3 false start no irq", irq_seen, 1'b0);
    send_frame(8'h5A, 1'b0);
    read_byte(8'h5A);
    wclk(BIT_T);

    // R9: frame during readout ignored
    send_frame(8'h35, 1'b0);
    send_frame(8'h4A, 1'b0);
    chk("R9 rxd holds stored bit0", rxd, 1'b1);
    read_byte(8'h35);
    irq_seen = 1'b0;
    wclk(12 * BIT_T);
    chk("R9 dropped frame not reported", irq_seen, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule